// File: doc/BRIEF.md
# Peripheral-to-Memory Byte DMA Channel with Modulo Destination

This block is one DMA channel that moves single bytes from a peripheral data register into memory. The peripheral raises a request line. If the channel is enabled, holds a non-zero byte count and has not finished, it acknowledges the request in the same cycle. In that cycle it presents the fixed source address to the peripheral and issues one memory write of the returned byte at the current destination pointer. The destination pointer then advances by one. It can wrap inside a power-of-two window that software selects. The byte count falls by one per transfer. When it reaches zero the channel raises a done flag and stops.

For a receive ring that never stops, software reads the live destination pointer to find out how many bytes have arrived. At the same time it writes a large value back into the count, so the countdown restarts and the channel never reaches zero. The window wrap only replaces the low address bits of the pointer. A ring must therefore be aligned to its window size, or bytes land below the start of the buffer.

Top module: `dmamod_top`

Register map (selected by `reg_sel`): 0 = source address, 1 = destination pointer, 2 = byte count (bits 19:0), 3 = control/status. In control/status, bit 0 enables requests, bit 1 enables the interrupt, bits 7:4 hold the window code k, and bit 24 is the done flag (write 1 to clear).

## Requirements
- R1: While a request is acknowledged, `per_addr` equals the source register, `mem_wdata` equals `per_data`, and `mem_addr` equals the destination pointer. After each transfer the pointer advances by one byte.
- R2: A request is acknowledged, with exactly one memory write in that cycle, only when it arrives while request enable (control bit 0) is 1, done is 0 and the count is non-zero. `mem_we` and `per_ack` are high together and only in such cycles.
- R3: Each transfer lowers the count by one. The transfer that takes the count from 1 to 0 sets done (control bit 24). The count then stays at 0 and further requests are not acknowledged.
- R4: A non-zero window code k in control bits 7:4 selects a window of 2^(k+3) bytes. When the pointer steps past the window's end, its low k+3 bits become zero and all upper bits are kept. A buffer that starts off a window boundary therefore continues below its start.
- R5: A window code of 0 disables wrapping, so the increment carries into the upper address bits.
- R6: Writing control/status with bit 24 set clears done. Writing it with bit 24 clear leaves done unchanged.
- R7: Writing the count while the channel is active restarts the countdown from the written value, with values up to 0xFFFF0 held exactly. The destination pointer is left unchanged.
- R8: Register 1 returns the live destination pointer at any time.
- R9: While request enable is 0, requests are ignored: no acknowledge, no write, and the pointer and count are unchanged.
- R10: While done is 1, no transfer occurs, even after the count is rewritten to a non-zero value, until done is cleared.
- R11: `irq` is high exactly while done is 1 and interrupt enable (control bit 1) is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| per_req | input | 1 | Peripheral transfer request |
| per_ack | output | 1 | Request served this cycle |
| per_addr | output | 32 | Fixed peripheral source address |
| per_data | input | 8 | Byte returned by the peripheral |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 32 | Memory write address |
| mem_wdata | output | 8 | Memory write byte |
| irq | output | 1 | Done interrupt |

## Verification
The bench targets wrap positions. A buffer that starts mid-window must continue at the aligned window base. A design that wraps to the programmed start, or that clears the upper bits, would write to the wrong last address. A carry across a window-sized boundary with wrapping off catches a design that wraps anyway. The bench also checks the final transfer: a count that rolls over instead of stopping would keep acknowledging requests. A rewrite of the count in the middle of a run must not move the pointer, and done must keep blocking transfers until it is cleared with a one.

// File: rtl/dmamod_pkg.sv
package dmamod_pkg;

    typedef enum logic [1:0] {
        SEL_SRC = 2'd0,
        SEL_DST = 2'd1,
        SEL_CNT = 2'd2,
        SEL_CTL = 2'd3
    } reg_sel_e;

    localparam int unsigned CTL_ERQ    = 0;
    localparam int unsigned CTL_IE     = 1;
    localparam int unsigned CTL_MOD_LO = 4;
    localparam int unsigned CTL_DONE   = 24;
    localparam int unsigned WIN_BASE   = 3;   // window bytes = 2^(k+WIN_BASE)

endpackage

// File: rtl/dmamod_wrap.sv
module dmamod_wrap #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned MOD_W  = 4
) (
    input  logic [ADDR_W-1:0] cur,
    input  logic [MOD_W-1:0]  sel,
    output logic [ADDR_W-1:0] nxt,
    output logic [ADDR_W-1:0] keep_mask
);
    import dmamod_pkg::*;

    logic [ADDR_W-1:0] win;
    logic [ADDR_W-1:0] inc;

    always_comb begin
        inc = cur + ADDR_W'(1);
        win = '0;
        if (sel != '0) begin
            win = (ADDR_W'(1) << (int'(sel) + int'(WIN_BASE))) - ADDR_W'(1);
        end
        keep_mask = ~win;
        if (sel == '0) begin
            nxt = inc;
        end else begin
            nxt = (cur & ~win) | (inc & win);
        end
    end

endmodule

// File: rtl/dmamod_gate.sv
module dmamod_gate (
    input  logic req,
    input  logic erq,
    input  logic done,
    input  logic cnt_zero,
    output logic go
);
    always_comb begin
        go = req & erq & ~done & ~cnt_zero;
    end

endmodule

// File: rtl/dmamod_regs.sv
module dmamod_regs #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned CNT_W  = 20,
    parameter int unsigned MOD_W  = 4,
    parameter int unsigned REG_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [1:0]        sel,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    input  logic              go,
    input  logic [ADDR_W-1:0] dst_nxt,
    output logic [ADDR_W-1:0] src,
    output logic [ADDR_W-1:0] dst,
    output logic [CNT_W-1:0]  cnt,
    output logic              erq,
    output logic              ie,
    output logic [MOD_W-1:0]  dmod,
    output logic              done
);
    import dmamod_pkg::*;

    typedef struct packed {
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [CNT_W-1:0]  cnt;
        logic              erq;
        logic              ie;
        logic [MOD_W-1:0]  dmod;
        logic              done;
    } chan_t;

    chan_t s_d, s_q;
    logic  done_clr;
    logic  last_xfer;

    always_comb begin
        s_d       = s_q;
        done_clr  = we && (reg_sel_e'(sel) == SEL_CTL) && wdata[CTL_DONE];
        last_xfer = go && (s_q.cnt == CNT_W'(1));
        if (go) begin
            s_d.dst = dst_nxt;
            s_d.cnt = s_q.cnt - CNT_W'(1);
        end
        if (we) begin
            case (reg_sel_e'(sel))
                SEL_SRC: s_d.src = ADDR_W'(wdata);
                SEL_DST: s_d.dst = ADDR_W'(wdata);
                SEL_CNT: s_d.cnt = wdata[CNT_W-1:0];
                SEL_CTL: begin
                    s_d.erq  = wdata[CTL_ERQ];
                    s_d.ie   = wdata[CTL_IE];
                    s_d.dmod = wdata[CTL_MOD_LO +: MOD_W];
                end
                default: ;
            endcase
        end
        s_d.done = (s_q.done & ~done_clr) | last_xfer;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        rdata = '0;
        case (reg_sel_e'(sel))
            SEL_SRC: rdata = REG_W'(s_q.src);
            SEL_DST: rdata = REG_W'(s_q.dst);
            SEL_CNT: rdata = REG_W'(s_q.cnt);
            SEL_CTL: begin
                rdata[CTL_ERQ]               = s_q.erq;
                rdata[CTL_IE]                = s_q.ie;
                rdata[CTL_MOD_LO +: MOD_W]   = s_q.dmod;
                rdata[CTL_DONE]              = s_q.done;
            end
            default: ;
        endcase
    end

    assign src  = s_q.src;
    assign dst  = s_q.dst;
    assign cnt  = s_q.cnt;
    assign erq  = s_q.erq;
    assign ie   = s_q.ie;
    assign dmod = s_q.dmod;
    assign done = s_q.done;

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !(we && reg_sel_e'(sel) == SEL_CNT)) |=> (s_q.cnt == $past(s_q.cnt) - CNT_W'(1))) // R3
        else $error("count did not step down");

    AST_DONE_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.done) |-> ($past(s_q.cnt) == CNT_W'(1) && $past(go))) // R3
        else $error("done rose without final transfer");

    AST_DONE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.done && !(we && reg_sel_e'(sel) == SEL_CTL)) |=> s_q.done) // R6
        else $error("done dropped without clear");

endmodule

// File: rtl/dmamod_top.sv
module dmamod_top #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned CNT_W  = 20,
    parameter int unsigned MOD_W  = 4,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned REG_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              per_req,
    output logic              per_ack,
    output logic [ADDR_W-1:0] per_addr,
    input  logic [DATA_W-1:0] per_data,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              irq
);
    import dmamod_pkg::*;

    logic [ADDR_W-1:0] src, dst, dst_nxt, keep_mask;
    logic [CNT_W-1:0]  cnt;
    logic              erq, ie, done, go;
    logic [MOD_W-1:0]  dmod;

    dmamod_regs #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .MOD_W(MOD_W), .REG_W(REG_W)
    ) i_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .sel(reg_sel),
        .wdata(reg_wdata), .rdata(reg_rdata), .go(go), .dst_nxt(dst_nxt),
        .src(src), .dst(dst), .cnt(cnt), .erq(erq), .ie(ie),
        .dmod(dmod), .done(done)
    );

    dmamod_wrap #(.ADDR_W(ADDR_W), .MOD_W(MOD_W)) i_wrap (
        .cur(dst), .sel(dmod), .nxt(dst_nxt), .keep_mask(keep_mask)
    );

    dmamod_gate i_gate (
        .req(per_req), .erq(erq), .done(done),
        .cnt_zero(cnt == '0), .go(go)
    );

    assign per_ack   = go;
    assign mem_we    = go;
    assign per_addr  = src;
    assign mem_addr  = dst;
    assign mem_wdata = per_data;
    assign irq       = done & ie;

    logic dst_wr, ctl_wr;
    assign dst_wr = reg_we && (reg_sel_e'(reg_sel) == SEL_DST);
    assign ctl_wr = reg_we && (reg_sel_e'(reg_sel) == SEL_CTL);

    AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        per_ack |-> (per_req && erq)) // R2
        else $error("ack without enabled request");

    AST_NO_XFER_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 || done) |-> !mem_we) // R10
        else $error("transfer while stopped");

    AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (go && dmod == '0 && !dst_wr && !ctl_wr) |=> (dst == $past(dst) + ADDR_W'(1))) // R5
        else $error("linear step wrong");

    AST_WINDOW_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (go && dmod != '0 && !dst_wr && !ctl_wr) |=> ((dst & keep_mask) == $past(dst & keep_mask))) // R4
        else $error("upper bits left window");

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!go && !dst_wr) |=> $stable(dst)) // R9
        else $error("pointer moved without transfer");

    AST_IRQ_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (done && ie)) // R11
        else $error("irq without done");

endmodule

// File: tb/test_dmamod_top.sv
module test_dmamod_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        per_req = 1'b0;
    logic        per_ack;
    logic [31:0] per_addr;
    logic [7:0]  per_data = '0;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        irq;

    int n_chk = 0;
    int n_err = 0;
    logic [31:0] last_wr;
    int          n_wr;

    localparam logic [31:0] SRC_A = 32'h4006_B007;

    always #2.5 clk = ~clk;

    dmamod_top i_dmamod_top (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .per_req(per_req),
        .per_ack(per_ack), .per_addr(per_addr), .per_data(per_data),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .irq(irq)
    );

    typedef struct packed {
        logic [3:0]  k;
        logic [31:0] start;
        logic [7:0]  n;
        logic [31:0] last;
        logic [31:0] fin;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{k: 4'd0, start: 32'h0000_0100, n: 8'd5,  last: 32'h0000_0104, fin: 32'h0000_0105},
        '{k: 4'd1, start: 32'h0000_020C, n: 8'd6,  last: 32'h0000_0201, fin: 32'h0000_0202},
        '{k: 4'd2, start: 32'h0000_03F8, n: 8'd10, last: 32'h0000_03E1, fin: 32'h0000_03E2},
        '{k: 4'd0, start: 32'h0000_0FFE, n: 8'd4,  last: 32'h0000_1001, fin: 32'h0000_1002},
        '{k: 4'd7, start: 32'h0200_03FE, n: 8'd3,  last: 32'h0200_0000, fin: 32'h0200_0001}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] s, output logic [31:0] d);
        @(negedge clk);
        reg_sel = s;
        #1 d = reg_rdata;
    endtask

    // hold request for n cycles, recording acknowledged writes
    task automatic pulse(input int n, input string req);
        n_wr = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            per_req = 1'b1;
            per_data = 8'hA0 + 8'(i);
            #1;
            if (mem_we) begin
                n_wr++;
                last_wr = mem_addr;
                check({req, " data"}, {24'h0, mem_wdata}, {24'h0, per_data});
                check({req, " src"}, per_addr, SRC_A);
                check({req, " ack"}, {31'h0, per_ack}, 32'h1);
            end
        end
        @(negedge clk);
        per_req = 1'b0;
    endtask

    initial begin
        #200000;
        n_err++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state
        rd(2'd1, v); check("R8 reset dst", v, 32'h0);
        rd(2'd3, v); check("R3 reset ctl", v, 32'h0);
        check("R11 reset irq", {31'h0, irq}, 32'h0);

        wr(2'd0, SRC_A);

        // R9: request enable off
        wr(2'd1, 32'h500); wr(2'd2, 32'd4); wr(2'd3, 32'h0);
        pulse(3, "R9");
        check("R9 no writes", n_wr, 0);
        rd(2'd1, v); check("R9 dst kept", v, 32'h500);
        rd(2'd2, v); check("R9 cnt kept", v, 32'd4);

        // table of wrap cases (R1 R4 R5 R3)
        foreach (VECS[j]) begin
            wr(2'd1, VECS[j].start);
            wr(2'd2, {24'h0, VECS[j].n});
            wr(2'd3, {24'h0, VECS[j].k, 4'h1});
            pulse(int'(VECS[j].n) + 2, "R1");
            check("R3 exact count", n_wr, int'(VECS[j].n));
            check("R4 R5 last addr", last_wr, VECS[j].last);
            rd(2'd1, v); check("R8 final dst", v, VECS[j].fin);
            rd(2'd2, v); check("R3 cnt zero", v, 32'h0);
            rd(2'd3, v); check("R3 done set", {31'h0, v[24]}, 32'h1);
            wr(2'd3, {7'h0, 1'b1, 16'h0, VECS[j].k, 4'h1});
            rd(2'd3, v); check("R6 done clear", {31'h0, v[24]}, 32'h0);
        end

        // count zero with done clear: no transfer
        pulse(2, "R2");
        check("R2 zero count ignored", n_wr, 0);

        // R7: rewrite count mid-run
        wr(2'd1, 32'h800); wr(2'd2, 32'd3); wr(2'd3, 32'h1);
        pulse(1, "R7");
        rd(2'd1, v); check("R7 dst after one", v, 32'h801);
        wr(2'd2, 32'h000F_FFF0);
        rd(2'd2, v); check("R7 cnt max", v, 32'h000F_FFF0);
        rd(2'd1, v); check("R7 dst untouched", v, 32'h801);
        pulse(2, "R7");
        rd(2'd2, v); check("R7 countdown", v, 32'h000F_FFEE);
        rd(2'd1, v); check("R7 dst continues", v, 32'h803);

        // R10 R6 R11: done blocks, write-0 ignored, clear resumes, irq
        wr(2'd2, 32'd1); wr(2'd3, 32'h3);
        pulse(1, "R10");
        #1 check("R11 irq on done", {31'h0, irq}, 32'h1);
        wr(2'd2, 32'd5);
        pulse(3, "R10");
        check("R10 blocked", n_wr, 0);
        wr(2'd3, 32'h3);
        rd(2'd3, v); check("R6 write0 keeps done", {31'h0, v[24]}, 32'h1);
        wr(2'd3, 32'h0100_0001);
        #1 check("R11 irq cleared", {31'h0, irq}, 32'h0);
        pulse(2, "R10");
        check("R10 resumes", n_wr, 2);
        rd(2'd2, v); check("R3 cnt after resume", v, 32'd3);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    end

endmodule